// File: doc/BRIEF.md
# Serial Management Target

This block is the target side of a two-wire management bus. It runs on the management clock and watches a shared data line. It finds frames, checks the target address they carry against a parameter, and then either stores a 16-bit word into one of 32 local registers or returns one of those words on the same line. The pad is split into a received bit, a driven bit and an output enable for an external tristate buffer. The line is taken to be pulled high whenever no device drives it.

The surrounding core reaches the same 32 registers through a plain parallel port. This port has an address, write data, a write strobe and a read-data output. The read data is a combinational view of the addressed register. The bus master and the core can both write. The serial side wins when both write the same register on the same edge.

Top module: `mdio_target`

## Requirements
- R1: While `rst` is high on a rising clock edge, all 32 registers clear to 0, the frame decoder returns to preamble search and `mdio_oe` goes low after that edge.
- R2: A frame is accepted only if at least 32 consecutive 1 bits were sampled before its start field. A frame preceded by a 0 and then only 31 ones has no effect.
- R3: The start field must be 0 followed by 1. A frame with any other start field has no effect.
- R4: The opcode is 2 bits, first bit first: 01 is a write and 10 is a read. The codes 00 and 11 make the target drop the frame without writing or driving.
- R5: Target and register addresses are 5 bits each, sent most significant bit first. A target address different from `PHY_ADDR` makes the frame have no effect and leaves `mdio_oe` low.
- R6: In a write frame, the target ignores the two turnaround bits and takes 16 data bits, most significant bit first. The word is written to the addressed register on the edge that samples the last data bit, and not before.
- R7: In a read frame, the target leaves the first turnaround bit undriven and drives 0 for the second. It then drives the 16 bits of the register as it was when the register address completed, most significant bit first, each changing just after a rising edge. It releases the line after the last bit.
- R8: `mdio_oe` is high only during a matching read, for at most 17 consecutive cycles, and never while the master drives a write frame.
- R9: A `core_we` pulse writes `core_wdata` to register `core_addr`, and `core_rdata` always shows register `core_addr`. If the core and a serial write hit the same register on the same edge, the serial data is kept.
- R10: Frames separated by two idle clocks are all decoded; no extra recovery time is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock; all bits are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mdio_i | input | 1 | Level seen on the shared data line |
| mdio_o | output | 1 | Bit driven onto the line when enabled |
| mdio_oe | output | 1 | Enable for the external tristate driver |
| core_addr | input | 5 | Core-side register select for reads and writes |
| core_we | input | 1 | Core-side write strobe |
| core_wdata | input | 16 | Core-side write data |
| core_rdata | output | 16 | Contents of register `core_addr` |

## Verification
The embedded properties watch the line-driving rules on every cycle. After reset the line is released. Each drive period opens with a 0 and closes in preamble search, and it never lasts more than 17 cycles. A serial or core write shows up on the core read port one edge later, and the serial side wins a collision. Only the bench's scenarios can show the frame-level behaviour. These cover full address sweeps of serial writes and reads with arithmetic data patterns, rejection of short preambles, bad start fields, unknown opcodes and foreign target addresses, the exact cycle of the write commit, and line contention between master and target.

// File: rtl/mdio_tgt_pkg.sv
package mdio_tgt_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 5;
    localparam int NREG    = 1 << ADDR_W;
    localparam int PRE_LEN = 32;
    localparam int TA_LEN  = 2;
    localparam int CNT_W   = $clog2(PRE_LEN + 1);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    localparam logic [1:0] OPC_WR = 2'b01;
    localparam logic [1:0] OPC_RD = 2'b10;

    typedef enum logic [3:0] {
        S_HUNT,
        S_START,
        S_OPC,
        S_PHY,
        S_REG,
        S_WTA,
        S_WDATA,
        S_RTA,
        S_RDATA
    } fsm_e;

    typedef struct packed {
        logic  we;
        addr_t addr;
        word_t data;
    } wr_req_t;

    function automatic logic opc_known(logic [1:0] op);
        return (op == OPC_WR) || (op == OPC_RD);
    endfunction

endpackage

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_tgt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t ser_wr,
    input  addr_t   ser_raddr,
    output word_t   ser_rdata,
    input  logic    core_we,
    input  addr_t   core_addr,
    input  word_t   core_wdata,
    output word_t   core_rdata
);

    word_t           mem [NREG];
    logic [NREG-1:0] hit_ser;
    logic [NREG-1:0] hit_core;

    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign hit_ser[g]  = ser_wr.we && (ser_wr.addr == addr_t'(g));
        assign hit_core[g] = core_we && (core_addr == addr_t'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst)              mem[i] <= '0;
            else if (hit_ser[i])  mem[i] <= ser_wr.data;
            else if (hit_core[i]) mem[i] <= core_wdata;
        end
    end

    assign core_rdata = mem[core_addr];
    assign ser_rdata  = mem[ser_raddr];

    // R1
    reg_clear_chk: assert property (@(posedge clk) rst |=> core_rdata == '0);

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_tgt_pkg::*;
#(
    parameter addr_t PHY_ADDR = '0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    mdio_i,
    output logic    mdio_o,
    output logic    mdio_oe,
    output wr_req_t ser_wr,
    output addr_t   ser_raddr,
    input  word_t   ser_rdata
);

    localparam cnt_t PRE_FULL  = cnt_t'(PRE_LEN);
    localparam cnt_t ADDR_LAST = cnt_t'(ADDR_W - 1);
    localparam cnt_t DATA_LAST = cnt_t'(DATA_W - 1);
    localparam cnt_t DATA_END  = cnt_t'(DATA_W);
    localparam cnt_t TA_LAST   = cnt_t'(TA_LEN - 1);

    fsm_e  state;
    cnt_t  cnt;
    word_t sh;
    word_t tx;
    addr_t reg_q;
    logic  rd_q;
    logic  drv_q;
    logic  oe_q;

    addr_t      rx_addr;
    logic [1:0] rx_op;

    assign rx_addr   = {sh[ADDR_W-2:0], mdio_i};
    assign rx_op     = {sh[0], mdio_i};
    assign ser_raddr = rx_addr;
    assign mdio_o    = drv_q;
    assign mdio_oe   = oe_q;

    always_comb begin
        ser_wr.we   = (state == S_WDATA) && (cnt == DATA_LAST);
        ser_wr.addr = reg_q;
        ser_wr.data = {sh[DATA_W-2:0], mdio_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_HUNT;
            cnt   <= '0;
            sh    <= '0;
            tx    <= '0;
            reg_q <= '0;
            rd_q  <= 1'b0;
            drv_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            sh <= {sh[DATA_W-2:0], mdio_i};
            unique case (state)
                S_HUNT: begin
                    if (mdio_i) begin
                        if (cnt != PRE_FULL) cnt <= cnt + 1'b1;
                    end else if (cnt == PRE_FULL) begin
                        cnt   <= '0;
                        state <= S_START;
                    end else begin
                        cnt <= '0;
                    end
                end
                S_START: begin
                    cnt   <= '0;
                    state <= mdio_i ? S_OPC : S_HUNT;
                end
                S_OPC: begin
                    if (cnt == '0) begin
                        cnt <= cnt + 1'b1;
                    end else begin
                        cnt <= '0;
                        if (opc_known(rx_op)) begin
                            rd_q  <= (rx_op == OPC_RD);
                            state <= S_PHY;
                        end else begin
                            state <= S_HUNT;
                        end
                    end
                end
                S_PHY: begin
                    if (cnt == ADDR_LAST) begin
                        cnt   <= '0;
                        state <= (rx_addr == PHY_ADDR) ? S_REG : S_HUNT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_REG: begin
                    if (cnt == ADDR_LAST) begin
                        cnt   <= '0;
                        reg_q <= rx_addr;
                        if (rd_q) begin
                            tx    <= ser_rdata;
                            state <= S_RTA;
                        end else begin
                            state <= S_WTA;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_WTA: begin
                    if (cnt == TA_LAST) begin
                        cnt   <= '0;
                        state <= S_WDATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_WDATA: begin
                    if (cnt == DATA_LAST) begin
                        cnt   <= '0;
                        state <= S_HUNT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_RTA: begin
                    oe_q  <= 1'b1;
                    drv_q <= 1'b0;
                    cnt   <= '0;
                    state <= S_RDATA;
                end
                S_RDATA: begin
                    if (cnt == DATA_END) begin
                        oe_q  <= 1'b0;
                        drv_q <= 1'b0;
                        cnt   <= '0;
                        state <= S_HUNT;
                    end else begin
                        drv_q <= tx[DATA_W-1];
                        tx    <= {tx[DATA_W-2:0], 1'b0};
                        cnt   <= cnt + 1'b1;
                    end
                end
                default: state <= S_HUNT;
            endcase
        end
    end

    logic [4:0] oe_run;
    always_ff @(posedge clk) begin
        if (rst)          oe_run <= '0;
        else if (mdio_oe) oe_run <= oe_run + 5'd1;
        else              oe_run <= '0;
    end

    // R1
    oe_reset_chk: assert property (@(posedge clk) rst |=> !mdio_oe);

    // R7
    ta_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_oe) |-> !mdio_o);

    // R7
    release_hunt_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mdio_oe) |-> state == S_HUNT);

    // R8
    oe_window_chk: assert property (@(posedge clk) disable iff (rst)
        oe_run <= 5'd17);

endmodule

// File: rtl/mdio_target.sv
module mdio_target
    import mdio_tgt_pkg::*;
#(
    parameter addr_t PHY_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_we,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata
);

    wr_req_t ser_wr;
    addr_t   ser_raddr;
    word_t   ser_rdata;

    mdio_frame_fsm #(.PHY_ADDR(PHY_ADDR)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .ser_wr    (ser_wr),
        .ser_raddr (ser_raddr),
        .ser_rdata (ser_rdata)
    );

    mdio_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .ser_wr     (ser_wr),
        .ser_raddr  (ser_raddr),
        .ser_rdata  (ser_rdata),
        .core_we    (core_we),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .core_rdata (core_rdata)
    );

    // R6
    ser_commit_chk: assert property (@(posedge clk) disable iff (rst)
        ser_wr.we |=> (core_addr != $past(ser_wr.addr)) || (core_rdata == $past(ser_wr.data)));

    // R9
    core_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (core_we && !(ser_wr.we && ser_wr.addr == core_addr))
        |=> (core_addr != $past(core_addr)) || (core_rdata == $past(core_wdata)));

endmodule

// File: tb/sim_mdio_target.sv
module sim_mdio_target;

    localparam logic [4:0] PHY = 5'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_en = 1'b0;
    logic        m_drv = 1'b1;
    logic [4:0]  core_addr = '0;
    logic        core_we = 1'b0;
    logic [15:0] core_wdata = '0;
    logic [15:0] core_rdata;
    logic        mdio_o;
    logic        mdio_oe;
    logic        line;

    always #10 clk = ~clk;

    assign line = mdio_oe ? mdio_o : (m_en ? m_drv : 1'b1);

    mdio_target #(.PHY_ADDR(PHY)) u0 (
        .clk        (clk),
        .rst        (rst),
        .mdio_i     (line),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .core_addr  (core_addr),
        .core_we    (core_we),
        .core_wdata (core_wdata),
        .core_rdata (core_rdata)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [15:0] model [32];

    function automatic logic [15:0] wpat(int a, int salt);
        return 16'(a * 16'h0F1D + salt * 16'h3301 + 16'h8421);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(logic b);
        @(negedge clk);
        m_en  = 1'b1;
        m_drv = b;
        if (mdio_oe) check("R8 target drives while master drives", 1, 0);
    endtask

    task automatic release_bit(string req);
        @(negedge clk);
        m_en = 1'b0;
        check(req, {31'b0, mdio_oe}, 0);
    endtask

    task automatic hdr(int npre, logic [1:0] st, logic [1:0] op, logic [4:0] phy, logic [4:0] ra);
        for (int i = 0; i < npre; i++) put(1'b1);
        put(st[1]); put(st[0]);
        put(op[1]); put(op[0]);
        for (int i = 4; i >= 0; i--) put(phy[i]);
        for (int i = 4; i >= 0; i--) put(ra[i]);
    endtask

    task automatic wr(string req, logic [4:0] ra, logic [15:0] d, int npre = 32,
                      logic [1:0] st = 2'b01, logic [1:0] op = 2'b01,
                      logic [4:0] phy = PHY, bit lead0 = 1'b0);
        bit ok;
        ok = (npre >= 32) && (st == 2'b01) && (op == 2'b01) && (phy == PHY);
        core_addr = ra;
        if (lead0) put(1'b0);
        hdr(npre, st, op, phy, ra);
        put(1'b1); put(1'b0);
        for (int i = 15; i >= 0; i--) put(d[i]);
        #1 check({req, " before last edge"}, {16'b0, core_rdata}, {16'b0, model[ra]});
        @(negedge clk);
        m_en = 1'b0;
        #1 check(req, {16'b0, core_rdata}, {16'b0, ok ? d : model[ra]});
        if (ok) model[ra] = d;
        release_bit("R10 idle released");
    endtask

    task automatic rd(string req, logic [4:0] ra, logic [1:0] op = 2'b10, logic [4:0] phy = PHY);
        bit          ok;
        logic [15:0] got;
        int          oe_cnt;
        ok     = (op == 2'b10) && (phy == PHY);
        got    = '0;
        oe_cnt = 0;
        hdr(32, 2'b01, op, phy, ra);
        for (int t = 0; t < 19; t++) begin
            @(negedge clk);
            m_en = 1'b0;
            if (ok) begin
                if (t == 0 || t == 18)
                    check({req, " line released"}, {31'b0, mdio_oe}, 0);
                else if (t == 1)
                    check({req, " turnaround 0"}, {30'b0, mdio_oe, mdio_o}, 2'b10);
                else begin
                    check({req, " data enable"}, {31'b0, mdio_oe}, 1);
                    got[17-t] = line;
                end
            end else if (mdio_oe) begin
                oe_cnt++;
            end
        end
        if (ok) check({req, " data"}, {16'b0, got}, {16'b0, model[ra]});
        else    check({req, " no drive"}, oe_cnt, 0);
        release_bit("R10 idle released");
        release_bit("R10 idle released");
    endtask

    task automatic cw(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        core_addr  = a;
        core_wdata = d;
        core_we    = 1'b1;
        @(negedge clk);
        core_we = 1'b0;
        #1 check("R9 core write", {16'b0, core_rdata}, {16'b0, d});
        model[a] = d;
    endtask

    task automatic peek_all(string req);
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            core_addr = 5'(a);
            #1 check(req, {16'b0, core_rdata}, {16'b0, model[a]});
        end
    endtask

    bit done = 1'b0;

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        for (int a = 0; a < 32; a++) model[a] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 enable low in reset", {31'b0, mdio_oe}, 0);
        rst = 1'b0;
        peek_all("R1 registers cleared");

        // R6 R10: serial write sweep over every register, back to back
        for (int a = 0; a < 32; a++) wr("R6 serial write", 5'(a), wpat(a, 0));
        peek_all("R6 sweep via core");

        // R7: serial read sweep
        for (int a = 0; a < 32; a++) rd("R7 serial read", 5'(a));

        // R2: 31-one preamble after a forced 0
        wr("R2 short preamble", 5'd4, 16'h1234, 31, 2'b01, 2'b01, PHY, 1'b1);
        wr("R2 full preamble after 0", 5'd4, 16'h4321, 32, 2'b01, 2'b01, PHY, 1'b1);

        // R3: bad start field
        wr("R3 start 00", 5'd9, 16'h0F0F, 32, 2'b00);
        // R4: unknown opcodes for write and read
        wr("R4 opcode 00", 5'd10, 16'h5A5A, 32, 2'b01, 2'b00);
        wr("R4 opcode 11", 5'd11, 16'hA5A5, 32, 2'b01, 2'b11);
        rd("R4 read opcode 11", 5'd11, 2'b11);
        // R5: foreign target address
        wr("R5 foreign address write", 5'd12, 16'h0001, 32, 2'b01, 2'b01, 5'd2);
        rd("R5 foreign address read", 5'd12, 2'b10, 5'd19);
        rd("R5 resync read", 5'd12);

        // R9: core writes seen by serial reads
        for (int a = 0; a < 32; a += 5) cw(5'(a), wpat(a, 7));
        for (int a = 0; a < 32; a += 5) rd("R9 core then serial read", 5'(a));

        // R9: collision on the commit edge, serial wins
        d = 16'hC0DE;
        core_addr = 5'd7;
        hdr(32, 2'b01, 2'b01, PHY, 5'd7);
        put(1'b1); put(1'b0);
        for (int i = 15; i >= 0; i--) put(d[i]);
        core_wdata = 16'h1111;
        core_we    = 1'b1;
        @(negedge clk);
        core_we = 1'b0;
        m_en    = 1'b0;
        #1 check("R9 collision serial wins", {16'b0, core_rdata}, {16'b0, d});
        model[7] = d;
        release_bit("R10 idle released");
        rd("R9 collision readback", 5'd7);

        // R7: extreme patterns
        wr("R6 all ones", 5'd31, 16'hFFFF);
        rd("R7 all ones", 5'd31);
        wr("R6 all zeros", 5'd0, 16'h0000);
        rd("R7 all zeros", 5'd0);

        // R1: reset after traffic
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 enable low after reset", {31'b0, mdio_oe}, 0);
        rst = 1'b0;
        for (int a = 0; a < 32; a++) model[a] = '0;
        peek_all("R1 registers cleared after traffic");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule